// File: doc/BRIEF.md
# Snoop-Based Five-State Coherency Controller

This block keeps the first-level data caches of a small cluster coherent. It has no directory and holds no copy of any cache's tags. When a core misses or wants to write, it raises a request carrying a line address. The controller picks one requester in round-robin order. It then sends a snoop command to every other core and waits for each of them to report the state it held. When a snooped cache held the only up-to-date copy, the controller also waits for that cache to return the line data. Finally it tells the requester which state to install and whether the line came from a peer cache or must be fetched from memory.

Each core uses three channels. The controller drives the command channel. The core drives the response channel, which reports the state it held before the snoop, and the data channel, which returns the dirty line when the core held it as owned or modified. A snooped core updates its own state. On a share command, modified becomes owned, exclusive becomes shared, and any other state is kept. On an invalidate command, every state becomes invalid. Only one request is in flight at any time.

Top module: `coh_snoop_ctrl`

## Requirements
- R1: States are coded on 3 bits: invalid 0, shared 1, exclusive 2, owned 3, modified 4. A completion only ever reports shared, exclusive or modified.
- R2: When several cores request in the same cycle, exactly one is acknowledged. The search starts at the core after the last one served, wrapping around, and core 0 has first priority after reset. The `req_ack` bit is high, combinationally, in the idle cycle in which the request is taken.
- R3: A new request is acknowledged only after every snoop response and every awaited data beat of the current request has arrived and its completion has been signalled. After reset no snoop, acknowledge or completion is active.
- R4: In the cycle after the acknowledge, `snp_valid` is high for every core except the requester. `snp_inv` is 0 for a read and 1 for a write, and `snp_addr` holds the request address. Each core's `snp_valid` stays high until that core's `rsp_valid` is seen, and drops in the next cycle.
- R5: When a read snoops a core that answers modified (4) or owned (3), that core's data beat is forwarded on `cmp_line`. The completion reports shared with `cmp_peer` set.
- R6: When a read finds that no other core holds the line, the completion reports exclusive with `cmp_peer` clear and `cmp_line` zero, which means a memory fill.
- R7: When a read finds only shared or exclusive copies elsewhere, the completion reports shared with `cmp_peer` clear.
- R8: A write invalidates every other copy and completes as modified. When a snooped copy was modified or owned, its data is forwarded first and `cmp_peer` is set.
- R9: A data beat may arrive in the same cycle as its response or any number of cycles later. The completion is held back until the beat has been taken.
- R10: A response or data beat from a core that is not awaiting one (for example, the requester) is ignored and does not affect the completion.
- R11: `NUM_CORES` may be 1, 2 or 4. With one core, a read completes as exclusive and a write as modified, and no snoop is ever issued.
- R12: Across the cluster, a line held as modified or exclusive by one cache is held in no other cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Per-core request pending |
| req_write | input | NUM_CORES | Per-core request kind: 1 write/ownership, 0 read |
| req_addr | input | NUM_CORES x ADDR_W | Per-core line address |
| req_ack | output | NUM_CORES | One-hot: request taken this cycle |
| snp_valid | output | NUM_CORES | Per-core snoop command pending |
| snp_inv | output | 1 | Snoop kind: 1 invalidate, 0 share |
| snp_addr | output | ADDR_W | Snooped line address |
| rsp_valid | input | NUM_CORES | Per-core snoop response strobe |
| rsp_state | input | NUM_CORES x 3 | State held before the snoop |
| dat_valid | input | NUM_CORES | Per-core line data strobe |
| dat_line | input | NUM_CORES x LINE_W | Dirty line data |
| cmp_valid | output | NUM_CORES | One-hot completion to the requester |
| cmp_state | output | 3 | State the requester installs |
| cmp_peer | output | 1 | 1: line supplied by a peer cache; 0: fetch from memory |
| cmp_addr | output | ADDR_W | Completed line address |
| cmp_line | output | LINE_W | Forwarded line (zero on a memory fill) |

## Verification
The hardest case to reach from the ports is a completion that must wait for a late data beat from an owner, while another core's early response is already in, and while a core that was not snooped drives spurious strobes. The bench drives every core from a behavioural cache model. Each core has its own response delay and data lag, so the snoop windows overlap in different ways. The model's line states move through owned and modified, so forwarded data is requested from owners that answer both early and late. A directed run stretches one owner's data lag to six cycles and checks that the completion cannot arrive early. Another run injects a modified response from the requester itself while snoops are still pending.

// File: rtl/coh_pkg.sv
`timescale 1ns/1ps
package coh_pkg;

   typedef enum logic [2:0] {
      CS_INV = 3'd0,
      CS_SHR = 3'd1,
      CS_EXC = 3'd2,
      CS_OWN = 3'd3,
      CS_MOD = 3'd4
   } coh_state_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SNOOP = 2'd1,
      PH_DONE  = 2'd2
   } coh_phase_e;

   // A snooped copy whose data must travel to the requester
   function automatic logic holds_dirty(input logic [2:0] s);
      return (s == CS_OWN) || (s == CS_MOD);
   endfunction

   // Any valid copy at all
   function automatic logic holds_copy(input logic [2:0] s);
      return (s == CS_SHR) || (s == CS_EXC) || (s == CS_OWN) || (s == CS_MOD);
   endfunction

endpackage

// File: rtl/coh_rr_arb.sv
`timescale 1ns/1ps
module coh_rr_arb #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             take,
   output logic [N-1:0]     gnt,
   output logic [IDX_W-1:0] gnt_idx
);

   logic [IDX_W-1:0] last_q;
   logic             found;

   // search starts one past the last winner and wraps
   always_comb begin
      gnt     = '0;
      gnt_idx = '0;
      found   = 1'b0;
      for (int k = 1; k <= N; k++) begin
         int cand;
         cand = (int'(last_q) + k) % N;
         if (!found && req[cand]) begin
            found        = 1'b1;
            gnt[cand]    = 1'b1;
            gnt_idx      = IDX_W'(cand);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= IDX_W'(N - 1);
      end else if (take && found) begin
         last_q <= gnt_idx;
      end
   end

endmodule

// File: rtl/coh_snoop_track.sv
`timescale 1ns/1ps
module coh_snoop_track
   import coh_pkg::*;
#(
   parameter int N      = 4,
   parameter int LINE_W = 512
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [N-1:0]               mask,
   input  logic [N-1:0]               rsp_valid,
   input  logic [N-1:0][2:0]          rsp_state,
   input  logic [N-1:0]               dat_valid,
   input  logic [N-1:0][LINE_W-1:0]   dat_line,
   output logic [N-1:0]               pend_rsp,
   output logic                       busy,
   output logic                       any_copy,
   output logic                       any_dirty,
   output logic [LINE_W-1:0]          fwd_line
);

   logic [N-1:0]      pend_rsp_q, pend_dat_q;
   logic [N-1:0]      rsp_hit, rsp_dirty, rsp_copy, dat_take, dat_wait;
   logic              copy_q, dirty_q;
   logic [LINE_W-1:0] line_q, line_nx;

   // per-core acceptance of responses and data beats
   for (genvar i = 0; i < N; i++) begin : g_core
      assign rsp_hit[i]   = pend_rsp_q[i] & rsp_valid[i];
      assign rsp_dirty[i] = rsp_hit[i] & holds_dirty(rsp_state[i]);
      assign rsp_copy[i]  = rsp_hit[i] & holds_copy(rsp_state[i]);
      assign dat_take[i]  = dat_valid[i] & (pend_dat_q[i] | rsp_dirty[i]);
      assign dat_wait[i]  = rsp_dirty[i] & ~dat_valid[i];
   end

   always_comb begin
      line_nx = line_q;
      for (int i = 0; i < N; i++) begin
         if (dat_take[i]) line_nx = dat_line[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_rsp_q <= '0;
         pend_dat_q <= '0;
         copy_q     <= 1'b0;
         dirty_q    <= 1'b0;
         line_q     <= '0;
      end else if (start) begin
         pend_rsp_q <= mask;
         pend_dat_q <= '0;
         copy_q     <= 1'b0;
         dirty_q    <= 1'b0;
         line_q     <= '0;
      end else begin
         pend_rsp_q <= pend_rsp_q & ~rsp_hit;
         pend_dat_q <= (pend_dat_q & ~dat_take) | dat_wait;
         copy_q     <= copy_q  | (|rsp_copy);
         dirty_q    <= dirty_q | (|rsp_dirty);
         line_q     <= line_nx;
      end
   end

   assign pend_rsp  = pend_rsp_q;
   assign busy      = (|pend_rsp_q) | (|pend_dat_q);
   assign any_copy  = copy_q;
   assign any_dirty = dirty_q;
   assign fwd_line  = line_q;

endmodule

// File: rtl/coh_snoop_ctrl.sv
`timescale 1ns/1ps
module coh_snoop_ctrl
   import coh_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 32,
   parameter int LINE_W    = 512
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_CORES-1:0]                req_valid,
   input  logic [NUM_CORES-1:0]                req_write,
   input  logic [NUM_CORES-1:0][ADDR_W-1:0]    req_addr,
   output logic [NUM_CORES-1:0]                req_ack,
   output logic [NUM_CORES-1:0]                snp_valid,
   output logic                                snp_inv,
   output logic [ADDR_W-1:0]                   snp_addr,
   input  logic [NUM_CORES-1:0]                rsp_valid,
   input  logic [NUM_CORES-1:0][2:0]           rsp_state,
   input  logic [NUM_CORES-1:0]                dat_valid,
   input  logic [NUM_CORES-1:0][LINE_W-1:0]    dat_line,
   output logic [NUM_CORES-1:0]                cmp_valid,
   output logic [2:0]                          cmp_state,
   output logic                                cmp_peer,
   output logic [ADDR_W-1:0]                   cmp_addr,
   output logic [LINE_W-1:0]                   cmp_line
);

   localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

   // elaboration-time parameter checks
   if (!(NUM_CORES == 1 || NUM_CORES == 2 || NUM_CORES == 4)) begin : g_bad_cores
      $error("coh_snoop_ctrl: NUM_CORES must be 1, 2 or 4");
   end
   if (ADDR_W < 1 || LINE_W < 1) begin : g_bad_width
      $error("coh_snoop_ctrl: ADDR_W and LINE_W must be positive");
   end

   coh_phase_e             phase_q;
   logic [IDX_W-1:0]       own_q;
   logic                   wr_q;
   logic [ADDR_W-1:0]      addr_q;

   logic [NUM_CORES-1:0]   arb_req, gnt, own_oh, pend_rsp;
   logic [IDX_W-1:0]       gnt_idx;
   logic                   is_idle, start, busy, any_copy, any_dirty;
   logic [LINE_W-1:0]      fwd_line;

   assign is_idle = (phase_q == PH_IDLE);
   assign arb_req = req_valid & {NUM_CORES{is_idle}};
   assign start   = is_idle & (|gnt);

   coh_rr_arb #(.N(NUM_CORES), .IDX_W(IDX_W)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (arb_req),
      .take    (is_idle),
      .gnt     (gnt),
      .gnt_idx (gnt_idx)
   );

   coh_snoop_track #(.N(NUM_CORES), .LINE_W(LINE_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mask      (~gnt),
      .rsp_valid (rsp_valid),
      .rsp_state (rsp_state),
      .dat_valid (dat_valid),
      .dat_line  (dat_line),
      .pend_rsp  (pend_rsp),
      .busy      (busy),
      .any_copy  (any_copy),
      .any_dirty (any_dirty),
      .fwd_line  (fwd_line)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         own_q   <= '0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (start) begin
               own_q   <= gnt_idx;
               wr_q    <= req_write[gnt_idx];
               addr_q  <= req_addr[gnt_idx];
               phase_q <= PH_SNOOP;
            end
            PH_SNOOP: if (!busy) phase_q <= PH_DONE;
            PH_DONE:  phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_own
      assign own_oh[i] = (own_q == IDX_W'(i));
   end

   assign req_ack   = gnt;
   assign snp_valid = pend_rsp & {NUM_CORES{phase_q == PH_SNOOP}};
   assign snp_inv   = wr_q;
   assign snp_addr  = addr_q;
   assign cmp_valid = own_oh & {NUM_CORES{phase_q == PH_DONE}};
   assign cmp_state = wr_q ? CS_MOD : (any_copy ? CS_SHR : CS_EXC);
   assign cmp_peer  = any_dirty;
   assign cmp_addr  = addr_q;
   assign cmp_line  = fwd_line;

endmodule

// File: rtl/coh_snoop_ctrl_chk.sv
`timescale 1ns/1ps
module coh_snoop_ctrl_chk #(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 32,
   parameter int LINE_W    = 512
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_CORES-1:0] req_ack,
   input logic [NUM_CORES-1:0] snp_valid,
   input logic                 snp_inv,
   input logic [NUM_CORES-1:0] rsp_valid,
   input logic [NUM_CORES-1:0] cmp_valid,
   input logic [2:0]           cmp_state
);

   p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ack));

   p_cmp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmp_valid));

   p_no_ack_in_snoop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|snp_valid) |-> (req_ack == '0));

   p_no_ack_at_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmp_valid) |-> (req_ack == '0));

   p_cmp_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmp_valid) |-> (cmp_state == 3'd1 || cmp_state == 3'd2 || cmp_state == 3'd4));

   p_write_mod_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cmp_valid) && snp_inv) |-> (cmp_state == 3'd4));

   p_read_not_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((|cmp_valid) && !snp_inv) |-> (cmp_state != 3'd4));

   p_snp_vs_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmp_valid) |-> (snp_valid == '0));

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
      p_snp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (snp_valid[i] && !rsp_valid[i]) |=> snp_valid[i]);
      p_snp_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (snp_valid[i] && rsp_valid[i]) |=> !snp_valid[i]);
   end

endmodule

bind coh_snoop_ctrl coh_snoop_ctrl_chk #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W),
   .LINE_W    (LINE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ack   (req_ack),
   .snp_valid (snp_valid),
   .snp_inv   (snp_inv),
   .rsp_valid (rsp_valid),
   .cmp_valid (cmp_valid),
   .cmp_state (cmp_state)
);

// File: tb/coh_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module coh_snoop_ctrl_bench;
   import coh_pkg::*;

   localparam int NC = 4;
   localparam int AW = 32;
   localparam int LW = 128;
   localparam int NV = 12;

   // vector: [15:14] core, [13] write, [12:11] line, [10:8] state, [7] peer
   localparam logic [15:0] VEC [NV] = '{
      16'h0200, 16'h4100, 16'hA400, 16'hC180, 16'h4180, 16'h2480,
      16'h2400, 16'h6C00, 16'hAC80, 16'hD200, 16'hF400, 16'h0980
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NC-1:0]          req_valid = '0;
   logic [NC-1:0]          req_write = '0;
   logic [NC-1:0][AW-1:0]  req_addr  = '0;
   logic [NC-1:0]          req_ack;
   logic [NC-1:0]          snp_valid;
   logic                   snp_inv;
   logic [AW-1:0]          snp_addr;
   logic [NC-1:0]          rsp_valid = '0;
   logic [NC-1:0][2:0]     rsp_state = '0;
   logic [NC-1:0]          dat_valid = '0;
   logic [NC-1:0][LW-1:0]  dat_line  = '0;
   logic [NC-1:0]          cmp_valid;
   logic [2:0]             cmp_state;
   logic                   cmp_peer;
   logic [AW-1:0]          cmp_addr;
   logic [LW-1:0]          cmp_line;

   coh_snoop_ctrl #(.NUM_CORES(NC), .ADDR_W(AW), .LINE_W(LW)) u_coh_snoop_ctrl (
      .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_ack,
      .snp_valid, .snp_inv, .snp_addr, .rsp_valid, .rsp_state,
      .dat_valid, .dat_line, .cmp_valid, .cmp_state, .cmp_peer,
      .cmp_addr, .cmp_line
   );

   // single-core instance
   logic [0:0]          s_req_valid = '0;
   logic [0:0]          s_req_write = '0;
   logic [0:0][AW-1:0]  s_req_addr  = '0;
   logic [0:0]          s_req_ack, s_snp_valid, s_cmp_valid;
   logic                s_snp_inv, s_cmp_peer;
   logic [AW-1:0]       s_snp_addr, s_cmp_addr;
   logic [2:0]          s_cmp_state;
   logic [LW-1:0]       s_cmp_line;

   coh_snoop_ctrl #(.NUM_CORES(1), .ADDR_W(AW), .LINE_W(LW)) u_coh_snoop_ctrl_solo (
      .clk, .rst_n,
      .req_valid (s_req_valid), .req_write (s_req_write), .req_addr (s_req_addr),
      .req_ack   (s_req_ack),   .snp_valid (s_snp_valid), .snp_inv (s_snp_inv),
      .snp_addr  (s_snp_addr),  .rsp_valid ('0), .rsp_state ('0),
      .dat_valid ('0), .dat_line ('0),
      .cmp_valid (s_cmp_valid), .cmp_state (s_cmp_state), .cmp_peer (s_cmp_peer),
      .cmp_addr  (s_cmp_addr),  .cmp_line (s_cmp_line)
   );

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // behavioural cache model and responders
   logic [2:0]    st [NC][4];
   logic [LW-1:0] ln [NC][4];
   int            dly  [NC] = '{0, 2, 1, 0};
   int            dlag [NC] = '{0, 1, 2, 0};
   int            rcnt [NC] = '{0, 0, 0, 0};
   int            dcnt [NC] = '{0, 0, 0, 0};
   bit            rdone[NC] = '{0, 0, 0, 0};
   bit            dpend[NC] = '{0, 0, 0, 0};
   logic [LW-1:0] dline[NC];
   int            spur_req = 0, spur_done = 0, spur_core = 0;
   int            cmp_cnt = 0, wseq = 0;
   logic [NC-1:0] last_cv;
   logic [2:0]    last_st;
   logic          last_peer;
   logic [LW-1:0] last_line;

   initial begin
      for (int c = 0; c < NC; c++)
         for (int l = 0; l < 4; l++) begin
            st[c][l] = CS_INV;
            ln[c][l] = '0;
         end
   end

   always @(negedge clk) begin
      rsp_valid = '0;
      dat_valid = '0;
      if (rst_n) begin
         if (|cmp_valid) begin
            int r, l;
            bit pend;
            r = 0;
            for (int c = 0; c < NC; c++) if (cmp_valid[c]) r = c;
            l = int'(cmp_addr[1:0]);
            last_cv = cmp_valid; last_st = cmp_state;
            last_peer = cmp_peer; last_line = cmp_line;
            st[r][l] = cmp_state;
            if (cmp_state == CS_MOD) begin
               wseq++;
               ln[r][l] = LW'({8'hC0 + 8'(r), 8'(l), 16'(wseq)});
            end else if (cmp_peer) begin
               ln[r][l] = cmp_line;
            end
            pend = 1'b0;
            for (int c = 0; c < NC; c++) if (dpend[c]) pend = 1'b1;
            chk(!pend, "R9", "completion while data beat outstanding", LW'(pend), '0);
            for (int l2 = 0; l2 < 4; l2++) begin
               int nx, nv;
               nx = 0; nv = 0;
               for (int c = 0; c < NC; c++) begin
                  if (st[c][l2] == CS_MOD || st[c][l2] == CS_EXC) nx++;
                  if (st[c][l2] != CS_INV) nv++;
               end
               chk(nx == 0 || (nx == 1 && nv == 1), "R12", "unique holder of M/E",
                   LW'(nv), LW'(1));
            end
            cmp_cnt++;
         end
         for (int i = 0; i < NC; i++) begin
            int a;
            a = int'(snp_addr[1:0]);
            if (!snp_valid[i]) rdone[i] = 1'b0;
            else if (!rdone[i]) begin
               if (rcnt[i] >= dly[i]) begin
                  rsp_valid[i] = 1'b1;
                  rsp_state[i] = st[i][a];
                  if (st[i][a] == CS_MOD || st[i][a] == CS_OWN) begin
                     dpend[i] = 1'b1; dcnt[i] = 0; dline[i] = ln[i][a];
                  end
                  if (snp_inv) st[i][a] = CS_INV;
                  else if (st[i][a] == CS_MOD) st[i][a] = CS_OWN;
                  else if (st[i][a] == CS_EXC) st[i][a] = CS_SHR;
                  rdone[i] = 1'b1; rcnt[i] = 0;
               end else rcnt[i]++;
            end
            if (dpend[i]) begin
               if (dcnt[i] >= dlag[i]) begin
                  dat_valid[i] = 1'b1; dat_line[i] = dline[i]; dpend[i] = 1'b0;
               end else dcnt[i]++;
            end
         end
         if (spur_req != spur_done && (|snp_valid)) begin
            rsp_valid[spur_core] = 1'b1;
            rsp_state[spur_core] = CS_MOD;
            dat_valid[spur_core] = 1'b1;
            dat_line[spur_core]  = '1;
            spur_done = spur_req;
         end
      end
   end

   int last_k = 0;

   task automatic run_req(input int c, input bit wr, input int l,
                          input logic [2:0] es, input bit ep, input string tag);
      logic [LW-1:0] el;
      logic [NC-1:0] pm;
      int base, k;
      el = '0;
      if (ep)
         for (int p = 0; p < NC; p++)
            if (p != c && (st[p][l] == CS_MOD || st[p][l] == CS_OWN)) el = ln[p][l];
      pm = ~(NC'(1) << c);
      @(negedge clk);
      req_valid[c] = 1'b1; req_write[c] = wr; req_addr[c] = AW'(l);
      #1;
      chk(req_ack == (NC'(1) << c), "R2", "acknowledge of lone request", LW'(req_ack), LW'(NC'(1) << c));
      base = cmp_cnt;
      @(negedge clk);
      chk(snp_valid == pm, "R4", "snoop target set", LW'(snp_valid), LW'(pm));
      chk(snp_inv == wr && snp_addr == AW'(l), "R4", "snoop kind/address",
          LW'({snp_inv, snp_addr}), LW'({wr, AW'(l)}));
      req_valid[c] = 1'b0;
      k = 0;
      while (cmp_cnt == base && k < 300) begin @(posedge clk); k++; end
      last_k = k;
      chk(last_cv == (NC'(1) << c), tag, "completion target", LW'(last_cv), LW'(NC'(1) << c));
      chk(last_st == es, tag, "installed state", LW'(last_st), LW'(es));
      chk(last_peer == ep, tag, "peer supplied", LW'(last_peer), LW'(ep));
      chk(last_line == el, tag, "forwarded line", last_line, el);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(snp_valid == '0 && cmp_valid == '0 && req_ack == '0, "R3", "outputs in reset",
          LW'({snp_valid, cmp_valid, req_ack}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(snp_valid == '0 && cmp_valid == '0, "R3", "idle after reset",
          LW'({snp_valid, cmp_valid}), '0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         logic [15:0] e;
         string tg;
         e = VEC[v];
         if (e[13])                tg = "R8";
         else if (e[10:8] == 3'd2) tg = "R6";
         else if (e[7])            tg = "R5";
         else                      tg = "R7";
         run_req(int'(e[15:14]), e[13], int'(e[12:11]), e[10:8], e[7], tg);
      end

      // R10: requester itself strobes a modified response during the snoop
      spur_core = 1; spur_req++;
      run_req(1, 1'b0, 3, CS_EXC, 1'b0, "R10");
      chk(spur_done == spur_req, "R10", "spurious strobe was injected", LW'(spur_done), LW'(spur_req));

      // R9: owner returns its line six cycles after the response
      dlag[3] = 6;
      run_req(0, 1'b0, 2, CS_SHR, 1'b1, "R9");
      chk(last_k >= 7, "R9", "completion waited for late data", LW'(last_k), LW'(7));
      dlag[3] = 0;

      // R2: all cores at once, last served was core 0
      begin
         int order [4] = '{1, 2, 3, 0};
         int n, base, k;
         logic [NC-1:0] drop;
         n = 0; drop = '0; base = cmp_cnt; k = 0;
         @(negedge clk);
         req_write = '0;
         for (int c = 0; c < NC; c++) req_addr[c] = AW'(3);
         req_valid = '1;
         #1;
         while (n < 4 && k < 400) begin
            if (|req_ack) begin
               int g;
               g = 0;
               for (int c = 0; c < NC; c++) if (req_ack[c]) g = c;
               chk(g == order[n], "R2", "round-robin order", LW'(g), LW'(order[n]));
               chk(snp_valid == '0, "R3", "ack only when no snoop pending", LW'(snp_valid), '0);
               drop = req_ack;
               n++;
            end
            @(negedge clk);
            req_valid = req_valid & ~drop;
            drop = '0;
            #1;
            k++;
         end
         while (cmp_cnt < base + 4 && k < 800) begin @(posedge clk); k++; end
         chk(cmp_cnt == base + 4, "R3", "all four served one by one", LW'(cmp_cnt - base), LW'(4));
      end

      // R11: single-core cluster
      for (int w = 0; w < 2; w++) begin
         bit seen_snp, got;
         logic [2:0] es;
         es = (w == 1) ? CS_MOD : CS_EXC;
         seen_snp = 1'b0; got = 1'b0;
         @(negedge clk);
         s_req_valid = 1'b1; s_req_write = 1'(w); s_req_addr[0] = AW'(5);
         #1;
         chk(s_req_ack == 1'b1, "R11", "solo acknowledge", LW'(s_req_ack), LW'(1));
         @(negedge clk);
         s_req_valid = 1'b0;
         for (int k = 0; k < 20 && !got; k++) begin
            if (s_snp_valid != '0) seen_snp = 1'b1;
            if (s_cmp_valid == 1'b1) begin
               got = 1'b1;
               chk(s_cmp_state == es && !s_cmp_peer, "R11", "solo completion",
                   LW'({s_cmp_peer, s_cmp_state}), LW'(es));
            end
            @(negedge clk);
         end
         chk(got && !seen_snp, "R11", "solo done without snoop", LW'({got, seen_snp}), LW'(2));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule